// File: doc/BRIEF.md
# Dual-Threshold Power-of-Two Watchdog Timer

This block is a watchdog timer driven through a small register interface. A counter runs while the block is enabled and is brought back to zero only when software writes a two-step feed sequence to a dedicated feed register. Two thresholds are compared against the count since the last restart. Each threshold is picked from sixteen power-of-two periods. The earlier one is meant to raise a maskable interrupt. The later one asks the system for a reset.

Software programs one control register. It holds a global enable, an interrupt enable, a reset enable and two 4-bit period selects. It also holds two sticky flags: one for a pending interrupt and one recording that a watchdog reset was requested. The reset flag survives the reset request it records, so software can read it after the reboot. The parameter `MAX_EXP` sets the longest period, which is 2^MAX_EXP cycles. It defaults to 31. A bench can lower it to get short periods while the code-to-period relation stays the same.

Top module: `wdog_pow2`

## Requirements
- R1: After reset the control readback is 0x00000000, `irq` is 0 and `rstReq` is 0.
- R2: A control write (`wrSel`=0) loads these fields, and `ctrlRd` returns them:
  - `intSel` in bits 3:0
  - `rstSel` in bits 7:4
  - enable in bit 8
  - interrupt enable in bit 9
  - reset enable in bit 10

  Bit 12 is the interrupt flag and bit 13 is the reset flag. All other bits read 0.
- R3: A period select of code n gives a period P = 2^(MAX_EXP−n). With enable and interrupt enable set, the interrupt flag is set on exactly the P-th clock edge after the restart edge.
- R4: `irq` equals the interrupt flag ANDed with interrupt enable. Clearing interrupt enable masks `irq` but keeps the flag. The flag clears only when bit 12 is written as 1.
- R5: With enable and reset enable set, `rstReq` is high for exactly one cycle, starting at the P-th edge after the restart. The counter restarts at that same edge, so the next pulse comes P edges later.
- R6: The reset flag is set together with `rstReq`. Writing 0 to bit 13 leaves it set. Writing 1 to bit 13 clears it.
- R7: A feed-register write (`wrSel`=1) of low byte 0xA5, followed by a feed-register write of low byte 0x5A, restarts the counter at the edge of the second write.
- R8: Any other feed value between 0xA5 and 0x5A aborts the sequence. A 0x5A that does not follow 0xA5 does not restart the counter.
- R9: While enable is 0 the counter holds its value and no interrupt or reset event occurs. After re-enabling, counting resumes from the held value.
- R10: The two thresholds act independently:
  - the interrupt threshold fires without reset enable;
  - the reset threshold fires at its own later period;
  - a threshold reached while interrupt enable is 0 does not set the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control register, 1 feed register |
| wrData | input | 32 | Write data |
| ctrlRd | output | 32 | Control register readback, flags included |
| irq | output | 1 | Interrupt request, level |
| rstReq | output | 1 | Reset request, single-cycle pulse |

## Verification
If the feed-sequence state is wrong, a restart is accepted or refused at the wrong time. This moves the next threshold event by a whole period, so it shows at `irq` or `rstReq` within one period of the feed. A counter that is off by even one count moves the flag edge by one cycle. The bench samples on the exact edge where the flag should change, so this error is caught at once. A bad flag or enable register shows directly in `ctrlRd` one cycle after the write. A reset request that does not restart the counter is seen as a missing second pulse exactly one period later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int NUM_THR = 2;
  localparam int THR_INT = 0;
  localparam int THR_RST = 1;

  localparam int BIT_EN     = 8;
  localparam int BIT_INT_EN = 9;
  localparam int BIT_RST_EN = 10;
  localparam int BIT_IFLAG  = 12;
  localparam int BIT_RFLAG  = 13;

  localparam logic [7:0] FEED_FIRST  = 8'hA5;
  localparam logic [7:0] FEED_SECOND = 8'h5A;

  typedef struct packed {
    logic countEn;
    logic restart;
  } dpStrb_t;

  typedef struct packed {
    logic       rstEn;
    logic       intEn;
    logic       en;
    logic [3:0] rstSel;
    logic [3:0] intSel;
  } ctrlFields_t;

endpackage

// File: rtl/wdog_thresh.sv
module wdog_thresh #(
  parameter int MAX_EXP = 31,
  parameter int CW      = MAX_EXP + 1
) (
  input  logic [3:0]    sel,
  input  logic [CW-1:0] nextCnt,
  input  logic          countEn,
  output logic          hit
);
  logic [CW-1:0] period;

  always_comb begin
    period = CW'(1) << (MAX_EXP - int'(sel));
    hit    = countEn && (nextCnt == period);
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int MAX_EXP = 31,
  localparam int CW     = MAX_EXP + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrb_t                   strb,
  input  logic [NUM_THR-1:0][3:0]   selArr,
  output logic [NUM_THR-1:0]        hits,
  output logic [CW-1:0]             cntOut
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] nextCnt;

  assign nextCnt = cnt + CW'(1);
  assign cntOut  = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.restart) cnt <= '0;
    else if (strb.countEn) cnt <= nextCnt;
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    wdog_thresh #(.MAX_EXP(MAX_EXP), .CW(CW)) u_thr (
      .sel     (selArr[g]),
      .nextCnt (nextCnt),
      .countEn (strb.countEn),
      .hit     (hits[g])
    );
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    wrSel,
  input  logic [31:0]             wrData,
  input  logic [NUM_THR-1:0]      hits,
  output dpStrb_t                 strb,
  output logic [NUM_THR-1:0][3:0] selArr,
  output logic [31:0]             ctrlRd,
  output logic                    irq,
  output logic                    rstReq,
  output logic                    feedArmed
);
  ctrlFields_t fields;
  logic        intFlag;
  logic        rstFlag;
  logic        armed;
  logic        ctrlWr;
  logic        feedWr;
  logic        feedDone;
  logic        intEvent;
  logic        rstEvent;
  logic [7:0]  feedByte;
  logic        unusedWr;

  assign unusedWr = ^{wrData[31:14], wrData[11]};
  assign ctrlWr   = wrEn && !wrSel;
  assign feedWr   = wrEn && wrSel;
  assign feedByte = wrData[7:0];
  assign feedDone = feedWr && armed && (feedByte == FEED_SECOND);

  assign intEvent = hits[THR_INT] && fields.intEn && !feedDone;
  assign rstEvent = hits[THR_RST] && fields.rstEn && !feedDone;

  assign strb.restart = feedDone || rstEvent;
  assign strb.countEn = fields.en;

  assign selArr[THR_INT] = fields.intSel;
  assign selArr[THR_RST] = fields.rstSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fields <= '0;
    end else if (ctrlWr) begin
      fields.intSel <= wrData[3:0];
      fields.rstSel <= wrData[7:4];
      fields.en     <= wrData[BIT_EN];
      fields.intEn  <= wrData[BIT_INT_EN];
      fields.rstEn  <= wrData[BIT_RST_EN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armed <= 1'b0;
    else if (feedWr) armed <= (feedByte == FEED_FIRST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlag <= 1'b0;
      rstFlag <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      rstReq <= rstEvent;
      if (intEvent)                        intFlag <= 1'b1;
      else if (ctrlWr && wrData[BIT_IFLAG]) intFlag <= 1'b0;
      if (rstEvent)                        rstFlag <= 1'b1;
      else if (ctrlWr && wrData[BIT_RFLAG]) rstFlag <= 1'b0;
    end
  end

  assign irq       = intFlag && fields.intEn;
  assign feedArmed = armed;

  always_comb begin
    ctrlRd                = '0;
    ctrlRd[3:0]           = fields.intSel;
    ctrlRd[7:4]           = fields.rstSel;
    ctrlRd[BIT_EN]        = fields.en;
    ctrlRd[BIT_INT_EN]    = fields.intEn;
    ctrlRd[BIT_RST_EN]    = fields.rstEn;
    ctrlRd[BIT_IFLAG]     = intFlag;
    ctrlRd[BIT_RFLAG]     = rstFlag;
  end
endmodule

// File: rtl/wdog_pow2.sv
module wdog_pow2
  import wdog_pkg::*;
#(
  parameter int MAX_EXP = 31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  output logic [31:0] ctrlRd,
  output logic        irq,
  output logic        rstReq
);
  localparam int CNT_W = MAX_EXP + 1;

  dpStrb_t                 strb;
  logic [NUM_THR-1:0][3:0] selArr;
  logic [NUM_THR-1:0]      hits;
  logic [CNT_W-1:0]        cntVal;
  logic                    feedArmed;

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .hits      (hits),
    .strb      (strb),
    .selArr    (selArr),
    .ctrlRd    (ctrlRd),
    .irq       (irq),
    .rstReq    (rstReq),
    .feedArmed (feedArmed)
  );

  wdog_datapath #(.MAX_EXP(MAX_EXP)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .selArr (selArr),
    .hits   (hits),
    .cntOut (cntVal)
  );
endmodule

// File: rtl/wdog_pow2_chk.sv
module wdog_pow2_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic          wrSel,
  input logic [7:0]    wrByte,
  input logic [31:0]   ctrlRd,
  input logic          rstReq,
  input logic [CW-1:0] cntVal,
  input logic          feedArmed
);
  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R5
  rst_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (cntVal == '0));

  // R6
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> ctrlRd[13]);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRd[8] |=> !rstReq);

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[8] && !(wrEn && wrSel)) |=> $stable(cntVal));

  // R7
  feed_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (feedArmed && wrEn && wrSel && wrByte == 8'h5A) |=> (cntVal == '0));

  // R8
  feed_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && wrByte != 8'hA5) |=> !feedArmed);
endmodule

bind wdog_pow2 wdog_pow2_chk #(.CW(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrByte    (wrData[7:0]),
  .ctrlRd    (ctrlRd),
  .rstReq    (rstReq),
  .cntVal    (cntVal),
  .feedArmed (feedArmed)
);

// File: tb/wdog_pow2_tb.sv
module wdog_pow2_tb;
  localparam int MAX_EXP = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] ctrlRd;
  logic        irq;
  logic        rstReq;
  int          nChecks = 0;
  int          nFails = 0;

  always #2 clk = ~clk;

  wdog_pow2 #(.MAX_EXP(MAX_EXP)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctrlRd(ctrlRd), .irq(irq), .rstReq(rstReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic feed();
    regWrite(1'b1, 32'hA5);
    regWrite(1'b1, 32'h5A);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
    waitEdges(2);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    check("R1 ctrlRd", ctrlRd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rstReq", {31'b0, rstReq}, 32'h0);
  endtask

  task automatic tRegs();
    doReset();
    regWrite(1'b0, 32'hFFFF_F65A);
    check("R2 readback", ctrlRd, 32'h0000_065A);
  endtask

  task automatic tIntPeriod();
    doReset();
    regWrite(1'b0, 32'h30D);          // code 13 -> 8 cycles
    feed();
    waitEdges(7);
    check("R3 irq before P=8", {31'b0, irq}, 32'h0);
    waitEdges(1);
    check("R3 irq at P=8", {31'b0, irq}, 32'h1);
    check("R3 flag at P=8", {31'b0, ctrlRd[12]}, 32'h1);
    doReset();
    regWrite(1'b0, 32'h30B);          // code 11 -> 32 cycles
    feed();
    waitEdges(31);
    check("R3 irq before P=32", {31'b0, irq}, 32'h0);
    waitEdges(1);
    check("R3 irq at P=32", {31'b0, irq}, 32'h1);
  endtask

  task automatic tIrqSticky();
    doReset();
    regWrite(1'b0, 32'h30D);
    feed();
    waitEdges(18);
    check("R4 irq stays", {31'b0, irq}, 32'h1);
    regWrite(1'b0, 32'h10D);
    check("R4 irq masked", {31'b0, irq}, 32'h0);
    check("R4 flag kept", {31'b0, ctrlRd[12]}, 32'h1);
    regWrite(1'b0, 32'h30D);
    check("R4 irq unmasked", {31'b0, irq}, 32'h1);
    regWrite(1'b0, 32'h130D);
    check("R4 irq after clear", {31'b0, irq}, 32'h0);
    check("R4 flag cleared", {31'b0, ctrlRd[12]}, 32'h0);
  endtask

  task automatic tRst();
    doReset();
    regWrite(1'b0, 32'h5E0);          // rst code 14 -> 4 cycles
    feed();
    waitEdges(3);
    check("R5 rstReq before P=4", {31'b0, rstReq}, 32'h0);
    waitEdges(1);
    check("R5 rstReq at P=4", {31'b0, rstReq}, 32'h1);
    check("R6 flag set", {31'b0, ctrlRd[13]}, 32'h1);
    waitEdges(1);
    check("R5 pulse one cycle", {31'b0, rstReq}, 32'h0);
    waitEdges(2);
    check("R5 no early repeat", {31'b0, rstReq}, 32'h0);
    waitEdges(1);
    check("R5 repeat after restart", {31'b0, rstReq}, 32'h1);
    regWrite(1'b0, 32'h0);
    check("R6 write 0 keeps flag", ctrlRd, 32'h0000_2000);
    regWrite(1'b0, 32'h2000);
    check("R6 write 1 clears flag", ctrlRd, 32'h0);
  endtask

  task automatic tFeed();
    doReset();
    regWrite(1'b0, 32'h30C);          // code 12 -> 16 cycles
    feed();
    waitEdges(10);
    feed();
    waitEdges(15);
    check("R7 no irq after refeed", {31'b0, irq}, 32'h0);
    waitEdges(1);
    check("R7 irq P after refeed", {31'b0, irq}, 32'h1);
  endtask

  task automatic tAbort();
    doReset();
    regWrite(1'b0, 32'h30C);
    feed();
    waitEdges(8);
    regWrite(1'b1, 32'hA5);
    regWrite(1'b1, 32'h00);
    regWrite(1'b1, 32'h5A);
    waitEdges(1);
    check("R8 aborted not yet", {31'b0, irq}, 32'h0);
    waitEdges(1);
    check("R8 aborted sequence ignored", {31'b0, irq}, 32'h1);
    doReset();
    regWrite(1'b0, 32'h30C);
    feed();
    waitEdges(8);
    regWrite(1'b1, 32'h5A);
    waitEdges(5);
    check("R8 lone 5A not yet", {31'b0, irq}, 32'h0);
    waitEdges(1);
    check("R8 lone 5A ignored", {31'b0, irq}, 32'h1);
  endtask

  task automatic tDisable();
    int pulses;
    doReset();
    regWrite(1'b0, 32'h30C);
    feed();
    waitEdges(6);
    regWrite(1'b0, 32'h20C);          // count frozen at 8
    waitEdges(40);
    check("R9 no irq while disabled", {31'b0, irq}, 32'h0);
    regWrite(1'b0, 32'h30C);
    waitEdges(7);
    check("R9 resume not yet", {31'b0, irq}, 32'h0);
    waitEdges(1);
    check("R9 resume from held count", {31'b0, irq}, 32'h1);
    doReset();
    regWrite(1'b0, 32'h4F0);          // rstEn, code 15, en=0
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rstReq) pulses++;
    end
    check("R9 no reset while disabled", pulses, 32'h0);
  endtask

  task automatic tIndep();
    doReset();
    regWrite(1'b0, 32'h7CD);          // int 8 cycles, rst 16 cycles
    feed();
    waitEdges(8);
    check("R10 irq at int period", {31'b0, irq}, 32'h1);
    check("R10 no reset at int period", {31'b0, rstReq}, 32'h0);
    waitEdges(8);
    check("R10 reset at own period", {31'b0, rstReq}, 32'h1);
    doReset();
    regWrite(1'b0, 32'h10D);          // intEn=0
    feed();
    waitEdges(12);
    check("R10 masked threshold no flag", {31'b0, ctrlRd[12]}, 32'h0);
    regWrite(1'b0, 32'h30D);
    check("R10 no irq after enabling", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    tReset();
    tRegs();
    tIntPeriod();
    tIrqSticky();
    tRst();
    tFeed();
    tAbort();
    tDisable();
    tIndep();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule